// File: doc/BRIEF.md
# System-Bus to Peripheral-Bus Bridge

This block connects a pipelined AHB-style system bus to a two-phase APB-style peripheral bus. On the system side it is a slave: it samples each accepted address phase and keeps it in a register, so the master can move on to its next address phase. On the peripheral side it is the master. Each transfer there takes a setup cycle and then an enable cycle. Write data is taken from the system bus and forwarded. Read data from the peripheral is handed straight back to the system bus.

The bridge posts writes, so a lone write costs the master no wait states. Reads stall the system bus until the peripheral answers. A read that directly follows a write must wait while the write drains first. The peripheral-side address also drives a one-hot select decode over four fixed regions.

Top module: `ahb_apb_bridge`

## Requirements
- R1: While `hresetn` is low, and in the first cycle after it is released, `hready_out` is 1, `psel` is 0, `penable` is 0 and `hresp` is 2'b00. An asynchronous reset in the middle of a transfer returns the bridge to this idle state at once.
- R2: Every peripheral transfer takes exactly two cycles. In the first, `penable` is 0. In the second, `penable` is 1 and `psel`, `paddr` and `pwrite` are unchanged. `penable` is never high for two cycles in a row.
- R3: `psel[i]` is 1 during both cycles of a transfer exactly when `paddr[15:12]` equals i, for i in 0..3. For any other value of that field, no select bit is set, but the transfer still runs its two cycles. At most one select bit is ever set.
- R4: An address phase is accepted only when `hsel` is 1, `hready_in` is 1 and `htrans` is 2'b10 (NONSEQ) or 2'b11 (SEQ). `htrans` 2'b00 (IDLE), 2'b01 (BUSY), `hsel` low or `hready_in` low start no peripheral transfer.
- R5: A lone write adds no wait state. Its setup cycle is the second cycle after its address phase, and `pwrite` is 1. `pwdata` equals the `hwdata` from the write's data phase and stays stable through setup and enable.
- R6: A lone read adds one wait state. Its setup cycle directly follows its address phase, with `hready_out` low. In the enable cycle `hready_out` is high and `hrdata` equals `prdata`.
- R7: A read whose address phase falls in the data phase of a write gets exactly three wait states. Its setup cycle directly follows the write's enable cycle.
- R8: A run of write, read, write, read, issued back to back, reaches the peripheral bus in issue order. Each transfer carries its own address, direction and data, and each transfer ends before the next one starts.
- R9: With no transfer pending, `psel` and `penable` are 0 and `hready_out` is 1.
- R10: `hresp` is always 2'b00 (OKAY).
- R11: A write whose address phase falls in the data phase of a previous write gets two wait states. Its setup cycle directly follows the previous write's enable cycle, with `pwdata` holding the second write's data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| hclk | input | 1 | Clock for both buses |
| hresetn | input | 1 | Asynchronous reset, active low |
| hsel | input | 1 | Slave select from the system-bus decoder |
| haddr | input | ADDR_W | System-bus address |
| hwrite | input | 1 | Direction of the address phase, 1 = write |
| htrans | input | 2 | Transfer type of the address phase |
| hwdata | input | DATA_W | Write data, valid in the data phase |
| hready_in | input | 1 | System-bus ready, as seen by all slaves |
| hready_out | output | 1 | Ready driven by this bridge; low inserts a wait state |
| hresp | output | 2 | Response, always OKAY |
| hrdata | output | DATA_W | Read data returned to the system bus |
| paddr | output | ADDR_W | Peripheral address |
| pwrite | output | 1 | Peripheral direction, 1 = write |
| psel | output | NUM_PERIPH | One-hot peripheral select |
| penable | output | 1 | High in the enable cycle of a peripheral transfer |
| pwdata | output | DATA_W | Peripheral write data |
| prdata | input | DATA_W | Peripheral read data |

## Verification
A new address phase can be accepted in the same cycle that the bridge captures a posted write's data, or in the same cycle that a read completes in its enable cycle. Both cases are provoked by issuing the next transfer in exactly those cycles: a read or a write right behind a write, and a write right after a read's completing cycle. The bench then checks, cycle by cycle, the number of wait-state cycles on `hready_out` and the moment each setup cycle starts. A log of completed peripheral transfers confirms that nothing was dropped, duplicated or reordered, and that each write carried its own data.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

    localparam logic [1:0] TR_IDLE   = 2'b00;
    localparam logic [1:0] TR_BUSY   = 2'b01;
    localparam logic [1:0] TR_NONSEQ = 2'b10;
    localparam logic [1:0] TR_SEQ    = 2'b11;

    localparam logic [1:0] RESP_OKAY = 2'b00;

    // Sequencer states of the peripheral-side engine
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_WDATA   = 3'd1,  // write data phase on the system bus
        ST_WSETUP  = 3'd2,
        ST_WENABLE = 3'd3,
        ST_RSETUP  = 3'd4,
        ST_RENABLE = 3'd5
    } brg_state_e;

endpackage

// File: rtl/bridge_slot_decode.sv
module bridge_slot_decode #(
    parameter int ADDR_W     = 32,
    parameter int SLOT_LSB   = 12,
    parameter int SLOT_W     = 4,
    parameter int NUM_PERIPH = 4
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  active,
    output logic [NUM_PERIPH-1:0] sel
);

    logic [SLOT_W-1:0] slot;
    assign slot = addr[SLOT_LSB +: SLOT_W];

    for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_slot
        assign sel[i] = active && (slot == SLOT_W'(i));
    end

    // Upper and lower address bits take no part in the decode
    logic unused_addr;
    assign unused_addr = ^{addr[ADDR_W-1:SLOT_LSB+SLOT_W], addr[SLOT_LSB-1:0]};

endmodule

// File: rtl/bridge_ctrl.sv
module bridge_ctrl
    import bridge_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [ADDR_W-1:0] haddr,
    input  logic              hwrite,
    input  logic [DATA_W-1:0] hwdata,
    output logic              hready,
    output logic [ADDR_W-1:0] paddr,
    output logic              pwrite,
    output logic [DATA_W-1:0] pwdata,
    output logic              in_setup,
    output logic              in_enable
);

    typedef struct packed {
        brg_state_e        st;
        logic              hready;
        logic [ADDR_W-1:0] paddr;
        logic              pwrite;
        logic [DATA_W-1:0] pwdata;
        logic              pend_vld;
        logic [ADDR_W-1:0] pend_addr;
        logic              pend_wr;
    } ctrl_t;

    ctrl_t q, d;

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE, ST_RENABLE: begin
                if (take) begin
                    d.paddr  = haddr;
                    d.pwrite = hwrite;
                    d.st     = hwrite ? ST_WDATA : ST_RSETUP;
                    d.hready = hwrite;
                end else begin
                    d.st     = ST_IDLE;
                    d.hready = 1'b1;
                end
            end
            ST_WDATA: begin
                d.pwdata = hwdata;
                d.st     = ST_WSETUP;
                d.hready = !take;
                if (take) begin
                    d.pend_vld  = 1'b1;
                    d.pend_addr = haddr;
                    d.pend_wr   = hwrite;
                end
            end
            ST_WSETUP: begin
                d.st     = ST_WENABLE;
                d.hready = !(q.pend_vld || take);
                if (take) begin
                    d.pend_vld  = 1'b1;
                    d.pend_addr = haddr;
                    d.pend_wr   = hwrite;
                end
            end
            ST_WENABLE: begin
                if (q.pend_vld) begin
                    d.pend_vld = 1'b0;
                    d.paddr    = q.pend_addr;
                    d.pwrite   = q.pend_wr;
                    if (q.pend_wr) begin
                        // held data phase of the queued write ends here
                        d.pwdata = hwdata;
                        d.st     = ST_WSETUP;
                        d.hready = 1'b1;
                    end else begin
                        d.st     = ST_RSETUP;
                        d.hready = 1'b0;
                    end
                end else if (take) begin
                    d.paddr  = haddr;
                    d.pwrite = hwrite;
                    d.st     = hwrite ? ST_WDATA : ST_RSETUP;
                    d.hready = hwrite;
                end else begin
                    d.st     = ST_IDLE;
                    d.hready = 1'b1;
                end
            end
            ST_RSETUP: begin
                d.st     = ST_RENABLE;
                d.hready = 1'b1;
            end
            default: begin
                d.st     = ST_IDLE;
                d.hready = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= ST_IDLE;
            q.hready <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign hready    = q.hready;
    assign paddr     = q.paddr;
    assign pwrite    = q.pwrite;
    assign pwdata    = q.pwdata;
    assign in_setup  = (q.st == ST_WSETUP)  || (q.st == ST_RSETUP);
    assign in_enable = (q.st == ST_WENABLE) || (q.st == ST_RENABLE);

endmodule

// File: rtl/ahb_apb_bridge.sv
module ahb_apb_bridge
    import bridge_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int NUM_PERIPH = 4,
    parameter int SLOT_LSB   = 12,
    parameter int SLOT_W     = 4
) (
    input  logic                  hclk,
    input  logic                  hresetn,
    input  logic                  hsel,
    input  logic [ADDR_W-1:0]     haddr,
    input  logic                  hwrite,
    input  logic [1:0]            htrans,
    input  logic [DATA_W-1:0]     hwdata,
    input  logic                  hready_in,
    output logic                  hready_out,
    output logic [1:0]            hresp,
    output logic [DATA_W-1:0]     hrdata,
    output logic [ADDR_W-1:0]     paddr,
    output logic                  pwrite,
    output logic [NUM_PERIPH-1:0] psel,
    output logic                  penable,
    output logic [DATA_W-1:0]     pwdata,
    input  logic [DATA_W-1:0]     prdata
);

    logic take;
    logic in_setup;
    logic in_enable;

    assign take = hsel && hready_in &&
                  ((htrans == TR_NONSEQ) || (htrans == TR_SEQ));

    bridge_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk       (hclk),
        .rst_n     (hresetn),
        .take      (take),
        .haddr     (haddr),
        .hwrite    (hwrite),
        .hwdata    (hwdata),
        .hready    (hready_out),
        .paddr     (paddr),
        .pwrite    (pwrite),
        .pwdata    (pwdata),
        .in_setup  (in_setup),
        .in_enable (in_enable)
    );

    bridge_slot_decode #(
        .ADDR_W     (ADDR_W),
        .SLOT_LSB   (SLOT_LSB),
        .SLOT_W     (SLOT_W),
        .NUM_PERIPH (NUM_PERIPH)
    ) u_decode (
        .addr   (paddr),
        .active (in_setup || in_enable),
        .sel    (psel)
    );

    assign penable = in_enable;
    assign hrdata  = prdata;
    assign hresp   = RESP_OKAY;

endmodule

// File: rtl/bridge_checker.sv
module bridge_checker #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int NUM_PERIPH = 4
) (
    input logic                  hclk,
    input logic                  hresetn,
    input logic                  hready_out,
    input logic [ADDR_W-1:0]     paddr,
    input logic                  pwrite,
    input logic [NUM_PERIPH-1:0] psel,
    input logic                  penable,
    input logic [DATA_W-1:0]     pwdata
);

    logic sel_any;
    assign sel_any = |psel;

    assert_sel_onehot_R3: assert property (@(posedge hclk) disable iff (!hresetn)
        $onehot0(psel));

    assert_setup_to_enable_R2: assert property (@(posedge hclk) disable iff (!hresetn)
        (sel_any && !penable) |=>
            (penable && $stable(psel) && $stable(paddr) && $stable(pwrite)));

    assert_enable_one_cycle_R2: assert property (@(posedge hclk) disable iff (!hresetn)
        penable |=> !penable);

    assert_wdata_held_R5: assert property (@(posedge hclk) disable iff (!hresetn)
        (sel_any && !penable && pwrite) |=> $stable(pwdata));

    assert_read_setup_waits_R6: assert property (@(posedge hclk) disable iff (!hresetn)
        (sel_any && !penable && !pwrite) |-> !hready_out);

    assert_read_enable_ready_R6: assert property (@(posedge hclk) disable iff (!hresetn)
        (sel_any && penable && !pwrite) |-> hready_out);

endmodule

bind ahb_apb_bridge bridge_checker #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .NUM_PERIPH (NUM_PERIPH)
) u_chk (
    .hclk       (hclk),
    .hresetn    (hresetn),
    .hready_out (hready_out),
    .paddr      (paddr),
    .pwrite     (pwrite),
    .psel       (psel),
    .penable    (penable),
    .pwdata     (pwdata)
);

// File: tb/sim_ahb_apb_bridge.sv
`timescale 1ns/1ps
module sim_ahb_apb_bridge;

    localparam logic [1:0] IDLE_T = 2'b00;
    localparam logic [1:0] BUSY_T = 2'b01;
    localparam logic [1:0] NSEQ_T = 2'b10;
    localparam logic [1:0] SEQ_T  = 2'b11;

    logic        hclk = 1'b0;
    logic        hresetn = 1'b0;
    logic        hsel = 1'b0;
    logic [31:0] haddr = '0;
    logic        hwrite = 1'b0;
    logic [1:0]  htrans = 2'b00;
    logic [31:0] hwdata = '0;
    logic        hold_low = 1'b0;
    logic        hready_in;
    logic        hready_out;
    logic [1:0]  hresp;
    logic [31:0] hrdata;
    logic [31:0] paddr;
    logic        pwrite;
    logic [3:0]  psel;
    logic        penable;
    logic [31:0] pwdata;
    logic [31:0] prdata;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 hclk = ~hclk;

    function automatic logic [31:0] model_rd(input logic [31:0] a);
        return {~a[15:0], a[15:0]};
    endfunction

    assign hready_in = hready_out && !hold_low;
    assign prdata = (penable && !pwrite && (psel != 4'b0)) ? model_rd(paddr) : 32'hDEAD_BEEF;

    ahb_apb_bridge u0 (
        .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .haddr(haddr),
        .hwrite(hwrite), .htrans(htrans), .hwdata(hwdata),
        .hready_in(hready_in), .hready_out(hready_out), .hresp(hresp),
        .hrdata(hrdata), .paddr(paddr), .pwrite(pwrite), .psel(psel),
        .penable(penable), .pwdata(pwdata), .prdata(prdata)
    );

    // log of completed peripheral transfers
    logic [31:0] lg_addr [16];
    logic        lg_wr   [16];
    logic [31:0] lg_data [16];
    int          log_n = 0;

    always @(posedge hclk) begin
        if (hresetn && penable && log_n < 16) begin
            lg_addr[log_n] <= paddr;
            lg_wr[log_n]   <= pwrite;
            lg_data[log_n] <= pwrite ? pwdata : prdata;
            log_n          <= log_n + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge hclk);
    endtask

    task automatic drv(input logic s, input logic [1:0] tr, input logic [31:0] a, input logic w);
        hsel = s; htrans = tr; haddr = a; hwrite = w;
    endtask

    task automatic chk_idle(input string tag);
        chk({tag, " psel"}, psel, 0);
        chk({tag, " penable"}, penable, 0);
        chk({tag, " hready"}, hready_out, 1);
    endtask

    task automatic t_reset();
        chk_idle("R1 in reset");
        chk("R1 hresp", hresp, 2'b00);
        cyc(); hresetn = 1'b1;
        cyc(); chk_idle("R1 after release");
    endtask

    task automatic t_single_write();
        log_n = 0;
        cyc(); chk_idle("R9 before write"); drv(1, NSEQ_T, 32'h0000_1040, 1);
        cyc(); chk("R5 data phase ready", hready_out, 1); chk("R5 no early psel", psel, 0);
        drv(0, IDLE_T, 0, 0); hwdata = 32'hA5A5_0001;
        cyc(); chk("R2 setup psel", psel, 4'b0010); chk("R2 setup penable", penable, 0);
        chk("R5 paddr", paddr, 32'h0000_1040); chk("R5 pwrite", pwrite, 1);
        chk("R5 pwdata setup", pwdata, 32'hA5A5_0001);
        cyc(); chk("R2 enable", penable, 1); chk("R3 psel slot1", psel, 4'b0010);
        chk("R5 pwdata enable", pwdata, 32'hA5A5_0001);
        cyc(); chk_idle("R9 after write"); chk("R10 hresp", hresp, 2'b00);
    endtask

    task automatic t_single_read();
        cyc(); drv(1, NSEQ_T, 32'h0000_2010, 0);
        cyc(); drv(0, IDLE_T, 0, 0);
        chk("R6 setup wait", hready_out, 0); chk("R3 psel slot2", psel, 4'b0100);
        chk("R6 setup penable", penable, 0); chk("R6 pwrite", pwrite, 0);
        chk("R6 paddr", paddr, 32'h0000_2010);
        cyc(); chk("R6 enable", penable, 1); chk("R6 ready", hready_out, 1);
        chk("R6 hrdata", hrdata, model_rd(32'h0000_2010));
        cyc(); chk_idle("R9 after read");
    endtask

    task automatic t_write_read();
        cyc(); drv(1, NSEQ_T, 32'h0000_0300, 1);
        cyc(); chk("R7 write data ready", hready_out, 1);
        drv(1, NSEQ_T, 32'h0000_3044, 0); hwdata = 32'h1234_5678;
        cyc(); drv(0, IDLE_T, 0, 0);
        chk("R7 wait1", hready_out, 0); chk("R3 psel slot0", psel, 4'b0001);
        chk("R7 write pwdata", pwdata, 32'h1234_5678);
        cyc(); chk("R7 wait2", hready_out, 0); chk("R7 write enable", penable, 1);
        cyc(); chk("R7 wait3", hready_out, 0); chk("R3 psel slot3", psel, 4'b1000);
        chk("R7 read setup", penable, 0); chk("R7 read paddr", paddr, 32'h0000_3044);
        cyc(); chk("R7 read done", hready_out, 1); chk("R7 read enable", penable, 1);
        chk("R7 hrdata", hrdata, model_rd(32'h0000_3044));
        cyc(); chk_idle("R9 after write-read");
    endtask

    task automatic t_write_write();
        cyc(); drv(1, NSEQ_T, 32'h0000_0010, 1);
        cyc(); drv(1, NSEQ_T, 32'h0000_1020, 1); hwdata = 32'h0000_AAAA;
        cyc(); drv(0, IDLE_T, 0, 0); hwdata = 32'h0000_BBBB;
        chk("R11 wait1", hready_out, 0); chk("R11 first pwdata", pwdata, 32'h0000_AAAA);
        cyc(); chk("R11 wait2", hready_out, 0); chk("R11 first enable", penable, 1);
        cyc(); chk("R11 second ready", hready_out, 1); chk("R11 second psel", psel, 4'b0010);
        chk("R11 second setup", penable, 0); chk("R11 second pwdata", pwdata, 32'h0000_BBBB);
        cyc(); chk("R11 second enable", penable, 1);
        cyc(); chk_idle("R9 after write-write");
    endtask

    task automatic t_sequence();
        log_n = 0;
        cyc(); drv(1, NSEQ_T, 32'h0000_0100, 1);
        cyc(); drv(1, NSEQ_T, 32'h0000_3204, 0); hwdata = 32'h1111_0001;
        cyc(); drv(0, IDLE_T, 0, 0);
        cyc();
        cyc();
        cyc(); chk("R8 first read ready", hready_out, 1);
        chk("R8 first read data", hrdata, model_rd(32'h0000_3204));
        drv(1, NSEQ_T, 32'h0000_2008, 1);
        cyc(); chk("R8 second write data phase", hready_out, 1);
        drv(1, SEQ_T, 32'h0000_1310, 0); hwdata = 32'h3333_0003;
        cyc(); drv(0, IDLE_T, 0, 0);
        cyc();
        cyc();
        cyc(); chk("R8 second read ready", hready_out, 1);
        chk("R8 second read data", hrdata, model_rd(32'h0000_1310));
        cyc();
        chk("R8 transfer count", log_n, 4);
        chk("R8 t0 addr", lg_addr[0], 32'h0000_0100); chk("R8 t0 dir", lg_wr[0], 1);
        chk("R8 t0 data", lg_data[0], 32'h1111_0001);
        chk("R8 t1 addr", lg_addr[1], 32'h0000_3204); chk("R8 t1 dir", lg_wr[1], 0);
        chk("R8 t2 addr", lg_addr[2], 32'h0000_2008); chk("R8 t2 dir", lg_wr[2], 1);
        chk("R8 t2 data", lg_data[2], 32'h3333_0003);
        chk("R8 t3 addr", lg_addr[3], 32'h0000_1310); chk("R8 t3 dir", lg_wr[3], 0);
    endtask

    task automatic t_unmapped();
        cyc(); drv(1, NSEQ_T, 32'h0000_5000, 1);
        cyc(); drv(0, IDLE_T, 0, 0); hwdata = 32'h0BAD_0005;
        cyc(); chk("R3 unmapped setup psel", psel, 0); chk("R3 unmapped paddr", paddr, 32'h0000_5000);
        cyc(); chk("R3 unmapped enable psel", psel, 0); chk("R3 unmapped still runs", penable, 1);
        cyc(); chk_idle("R9 after unmapped");
    endtask

    task automatic t_ignored();
        log_n = 0;
        for (int p = 0; p < 4; p++) begin
            cyc();
            case (p)
                0: drv(0, NSEQ_T, 32'h0000_0000, 1);
                1: drv(1, IDLE_T, 32'h0000_1000, 0);
                2: drv(1, BUSY_T, 32'h0000_2000, 1);
                default: begin drv(1, NSEQ_T, 32'h0000_3000, 0); hold_low = 1'b1; end
            endcase
            cyc(); drv(0, IDLE_T, 0, 0); hold_low = 1'b0;
            for (int k = 0; k < 3; k++) begin
                cyc(); chk_idle("R4 ignored phase");
            end
        end
        chk("R4 no transfer logged", log_n, 0);
    endtask

    task automatic t_reset_midway();
        cyc(); drv(1, NSEQ_T, 32'h0000_2100, 0);
        cyc(); drv(0, IDLE_T, 0, 0); chk("R1 pre-reset setup", psel, 4'b0100);
        #1 hresetn = 1'b0;
        #1 chk_idle("R1 async reset");
        cyc(); hresetn = 1'b1;
        cyc(); chk_idle("R1 after mid reset");
    endtask

    initial begin
        repeat (3) cyc();
        t_reset();
        t_single_write();
        t_single_read();
        t_write_read();
        t_write_write();
        t_sequence();
        t_unmapped();
        t_ignored();
        t_reset_midway();
        repeat (2) cyc();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge hclk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule